// File: doc/BRIEF.md
# I2C Target Controller with Firmware Clock Hold

This block is the target (slave) side of an I2C bus. It watches SCL and SDA through a short synchronizer and notices start, repeated start and stop conditions. It compares the address against its own 7-bit or 10-bit address and then moves data bytes in either direction. Both bus lines are driven open-drain through the output-enable pins, where 1 pulls the line low. Firmware configures the block through a small byte-wide register file. The same registers carry two overrides. The first forces a NACK on exactly the next byte. The second pins SCL low for as long as firmware wants, and when that hold begins depends on the level of SCL at the moment the request is made.

The protocol engine has seven states. ST_IDLE ignores everything except start and stop conditions. ST_ADDR shifts in the first address byte. ST_ADDR_LO shifts in the second byte of a 10-bit address. ST_RX shifts in data bytes. ST_ACK drives or releases SDA for the ninth clock. ST_TX shifts out a data byte. ST_TX_ACK samples the controller's acknowledge.

The transitions are as follows. A stop condition in any state goes to ST_IDLE. A start condition in any state goes to ST_ADDR. From ST_ADDR, ST_ADDR_LO or ST_RX, the falling SCL edge after the eighth bit goes to ST_ACK if the byte is accepted, and to ST_IDLE if it is not. From ST_ACK, the falling edge after the ninth clock goes to the saved follow-on state (ST_ADDR_LO, ST_RX or ST_TX) if an ACK was given, and to ST_IDLE otherwise. From ST_TX, the falling edge after the eighth bit goes to ST_TX_ACK. From ST_TX_ACK, the falling edge goes to ST_TX if the controller acknowledged, and to ST_IDLE if it did not.

A separate three-state holder drives SCL: SH_OFF, SH_ARMED and SH_HOLD. SH_OFF goes to SH_HOLD when a request arrives while SCL is low, and to SH_ARMED when a request arrives while SCL is high. SH_ARMED goes to SH_HOLD when SCL falls. Both SH_ARMED and SH_HOLD return to SH_OFF when the request is withdrawn.

Top module: `i2c_target_ctl`

Register map (byte-wide, selected by `reg_addr`):
- 0, control: bit 0 selects 10-bit mode, bit 1 requests stretch, bit 2 requests a one-shot NACK, bit 3 enables the send interrupt, bit 4 enables the receive interrupt, bit 5 enables the stop interrupt.
- 1, main address: bits 6:0 hold the 7-bit address; in 10-bit mode bits 1:0 hold address bits 9:8.
- 2, low address: address bits 7:0 in 10-bit mode.
- 3, status: bit 0 is byte sent, bit 1 is byte received, bit 2 is stop seen. Writing 1 to a bit clears it.
- 4, transmit byte (read/write).
- 5, received byte (read-only).

## Requirements
- R1: After reset, registers 0 to 3 read 0, `scl_oe`, `sda_oe` and `irq` are 0, and the engine is in ST_IDLE.
- R2: A start condition (SDA falls while SCL is high) starts address reception. Every stop condition (SDA rises while SCL is high) returns the engine to ST_IDLE and sets status bit 2.
- R3: In 7-bit mode, the first byte after a start, taken MSB first, is accepted when its bits 7:1 equal main-address bits 6:0. An accepted byte is answered with SDA low in the ninth clock. A byte that does not match gets no ACK, and the target ignores the bus until the next start.
- R4: After a write address is accepted, each data byte is shifted in MSB first. On its eighth bit it is stored in register 5 and status bit 1 is set, and the byte is then ACKed.
- R5: After a read address is accepted, register 4 is shifted out MSB first. Status bit 0 is set at the SCL fall that ends the eighth bit. A controller ACK causes register 4 to be sent again. A controller NACK releases SDA and returns the engine to ST_IDLE.
- R6: In 10-bit mode, the first byte must be 11110, then main-address bits 1:0, then 0. The next byte must then equal register 2. Both bytes are ACKed, and a mismatch in either byte is NACKed.
- R7: In 10-bit mode, after a complete 10-bit write match and without a stop in between, a repeated start followed by 11110, the high bits and 1 is ACKed and a read follows. Without that earlier match, the same byte is NACKed.
- R8: Setting control bit 2 makes the next byte the target would ACK (address or data) receive a NACK instead. The bit then clears itself, the target ignores the bus until the next start, and the next transfer is answered normally.
- R9: Setting control bit 1 while SCL is low asserts `scl_oe` within a few clocks. It stays asserted until the bit is cleared, and clearing the bit releases it.
- R10: Setting control bit 1 while SCL is high does not pull SCL low. The hold starts at the next SCL fall and lasts until the bit is cleared.
- R11: Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged.
- R12: `irq` is the OR over the three status bits, each ANDed with its enable (bit 0 with control bit 3, bit 1 with control bit 4, bit 2 with control bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong engine state shows up on the bus within one bit time. If the target misses a start or misreads an address bit, the ninth-clock ACK has the wrong level. If it lands in the wrong follow-on state, the next byte arrives in register 5 corrupted, or SDA stays driven when it should not be. A fault in the hold logic changes `scl_oe` a few clocks after the control write or after the next SCL fall. A fault in the status or interrupt path is visible on `irq` in the same cycle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W  = 8;
    localparam int AMAIN_W = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int REG_AW  = 3;
    localparam int REG_DW  = 8;
    localparam int CTRL_W  = 6;
    localparam int STAT_W  = 3;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_AMAIN = 3'd1;
    localparam logic [REG_AW-1:0] RA_ALOW  = 3'd2;
    localparam logic [REG_AW-1:0] RA_STAT  = 3'd3;
    localparam logic [REG_AW-1:0] RA_TXD   = 3'd4;
    localparam logic [REG_AW-1:0] RA_RXD   = 3'd5;

    localparam int CB_TEN     = 0;
    localparam int CB_STRETCH = 1;
    localparam int CB_NACK    = 2;
    localparam int CB_TXIE    = 3;
    localparam int CB_STOPIE  = 5;

    localparam int SB_RX = 1;

    localparam logic [4:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_LO, ST_RX, ST_ACK, ST_TX, ST_TX_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        SH_OFF, SH_ARMED, SH_HOLD
    } hold_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_ff[SYNC_STAGES-1];
            sda_p  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;
endmodule

// File: rtl/i2c_scl_hold.sv
module i2c_scl_hold import i2c_tgt_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_req,
    input  logic scl_s,
    output logic hold
);
    hold_state_e hst, hst_n;

    always_comb begin
        hst_n = hst;
        unique case (hst)
            SH_OFF:   if (stretch_req) hst_n = scl_s ? SH_ARMED : SH_HOLD;
            SH_ARMED: if (!stretch_req) hst_n = SH_OFF;
                      else if (!scl_s) hst_n = SH_HOLD;
            SH_HOLD:  if (!stretch_req) hst_n = SH_OFF;
            default:  hst_n = SH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hst <= SH_OFF;
        else        hst <= hst_n;
    end

    always_comb hold = (hst == SH_HOLD);

    // R9
    hold_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_req && !scl_s) |=> hold);
    // R10
    no_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst == SH_OFF && scl_s) |=> !hold);
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stretch_req |=> !hold);
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs import i2c_tgt_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              stop_evt,
    input  logic              nack_used,
    output logic              ten_bit,
    output logic              stretch_req,
    output logic              nack_req,
    output logic [AMAIN_W-1:0] own_main,
    output logic [BYTE_W-1:0] own_low,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl;
    logic [STAT_W-1:0] stat, clr, set;

    assign clr = (we && addr == RA_STAT) ? wdata[STAT_W-1:0] : '0;
    assign set = {stop_evt, rx_evt, tx_evt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            own_main <= '0;
            own_low  <= '0;
            tx_byte  <= '0;
            stat     <= '0;
        end else begin
            if (we && addr == RA_CTRL) ctrl <= wdata[CTRL_W-1:0];
            else if (nack_used)        ctrl[CB_NACK] <= 1'b0;
            if (we && addr == RA_AMAIN) own_main <= wdata[AMAIN_W-1:0];
            if (we && addr == RA_ALOW)  own_low  <= wdata;
            if (we && addr == RA_TXD)   tx_byte  <= wdata;
            stat <= (stat & ~clr) | set;
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL:  rdata = {{(REG_DW-CTRL_W){1'b0}}, ctrl};
            RA_AMAIN: rdata = {{(REG_DW-AMAIN_W){1'b0}}, own_main};
            RA_ALOW:  rdata = own_low;
            RA_STAT:  rdata = {{(REG_DW-STAT_W){1'b0}}, stat};
            RA_TXD:   rdata = tx_byte;
            RA_RXD:   rdata = rx_byte;
            default:  rdata = '0;
        endcase
    end

    assign ten_bit     = ctrl[CB_TEN];
    assign stretch_req = ctrl[CB_STRETCH];
    assign nack_req    = ctrl[CB_NACK];
    assign irq         = |(stat & ctrl[CB_STOPIE:CB_TXIE]);

    // R11
    w1c_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_STAT && wdata[SB_RX] && !rx_evt) |=> !stat[SB_RX]);
    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CB_STOPIE:CB_TXIE] == '0) |-> !irq);
    // R8
    nack_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_used && !(we && addr == RA_CTRL)) |=> !nack_req);
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm import i2c_tgt_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               ten_bit,
    input  logic [AMAIN_W-1:0] own_main,
    input  logic [BYTE_W-1:0]  own_low,
    input  logic               nack_req,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               sda_drive,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_evt,
    output logic               tx_evt,
    output logic               stop_evt,
    output logic               nack_used
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e state, state_n, after_st, after_n, byte_next;
    logic [BYTE_W-1:0] sh, sh_n, rxb_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic ack_ok, ack_n, ten_armed, ten_n, mack, mack_n, byte_hit;

    // acceptance of the byte just shifted in, and where to go after its ACK
    always_comb begin
        byte_hit  = 1'b0;
        byte_next = ST_RX;
        if (state == ST_ADDR_LO) begin
            byte_hit = (sh == own_low);
        end else if (state == ST_RX) begin
            byte_hit = 1'b1;
        end else if (!ten_bit) begin
            byte_hit  = (sh[BYTE_W-1:1] == own_main);
            byte_next = sh[0] ? ST_TX : ST_RX;
        end else if (sh[7:3] == TEN_HDR && sh[2:1] == own_main[1:0]) begin
            byte_hit  = !sh[0] || ten_armed;
            byte_next = sh[0] ? ST_TX : ST_ADDR_LO;
        end
    end

    always_comb begin
        state_n = state;  sh_n = sh;  cnt_n = cnt;  ack_n = ack_ok;
        after_n = after_st;  ten_n = ten_armed;  mack_n = mack;  rxb_n = rx_byte;
        rx_evt = 1'b0;  tx_evt = 1'b0;  stop_evt = 1'b0;  nack_used = 1'b0;
        if (stop_det) begin
            state_n  = ST_IDLE;
            ten_n    = 1'b0;
            stop_evt = 1'b1;
        end else if (start_det) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_ADDR, ST_ADDR_LO, ST_RX: begin
                    if (scl_rise && cnt != FULL) begin
                        sh_n  = {sh[BYTE_W-2:0], sda_s};
                        cnt_n = cnt + 1'b1;
                        if (state == ST_RX && cnt == LAST) begin
                            rx_evt = 1'b1;
                            rxb_n  = {sh[BYTE_W-2:0], sda_s};
                        end
                    end else if (scl_fall && cnt == FULL) begin
                        if (byte_hit) begin
                            state_n   = ST_ACK;
                            ack_n     = !nack_req;
                            nack_used = nack_req;
                            after_n   = byte_next;
                        end else begin
                            state_n = ST_IDLE;
                        end
                        if (state == ST_ADDR)
                            ten_n = ten_bit && sh[0] && byte_hit && !nack_req;
                        else if (state == ST_ADDR_LO)
                            ten_n = byte_hit && !nack_req;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    cnt_n = '0;
                    if (ack_ok) begin
                        state_n = after_st;
                        if (after_st == ST_TX) sh_n = tx_byte;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (cnt == LAST) begin
                        state_n = ST_TX_ACK;
                        tx_evt  = 1'b1;
                    end else begin
                        sh_n  = {sh[BYTE_W-2:0], 1'b0};
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) mack_n = !sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            state_n = ST_TX;
                            sh_n    = tx_byte;
                            cnt_n   = '0;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;  cnt <= '0;  ack_ok <= 1'b0;  after_st <= ST_IDLE;
            ten_armed <= 1'b0;  mack <= 1'b0;  rx_byte <= '0;
        end else begin
            sh <= sh_n;  cnt <= cnt_n;  ack_ok <= ack_n;  after_st <= after_n;
            ten_armed <= ten_n;  mack <= mack_n;  rx_byte <= rxb_n;
        end
    end

    always_comb sda_drive = (state == ST_ACK && ack_ok) || (state == ST_TX && !sh[BYTE_W-1]);

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR && cnt == '0));
    // R8
    nack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_used |-> nack_req);
    // R4
    event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_evt, tx_evt, stop_evt}));
    // R5
    tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !sda_drive);
endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl import i2c_tgt_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic ten_bit, stretch_req, nack_req, nack_used;
    logic rx_evt, tx_evt, stop_evt;
    logic [AMAIN_W-1:0] own_main;
    logic [BYTE_W-1:0]  own_low, tx_byte, rx_byte;

    i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2c_tgt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .rx_byte(rx_byte), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .stop_evt(stop_evt), .nack_used(nack_used), .ten_bit(ten_bit),
        .stretch_req(stretch_req), .nack_req(nack_req), .own_main(own_main),
        .own_low(own_low), .tx_byte(tx_byte), .irq(irq)
    );

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .start_det(start_det),
        .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .ten_bit(ten_bit), .own_main(own_main), .own_low(own_low),
        .nack_req(nack_req), .tx_byte(tx_byte), .sda_drive(sda_oe),
        .rx_byte(rx_byte), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .stop_evt(stop_evt), .nack_used(nack_used)
    );

    i2c_scl_hold u_hold (
        .clk(clk), .rst_n(rst_n), .stretch_req(stretch_req), .scl_s(scl_s), .hold(scl_oe)
    );
endmodule

// File: tb/test_i2c_target_ctl.sv
module test_i2c_target_ctl;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line, scl_oe, sda_oe, irq;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_target_ctl i_i2c_target_ctl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // vectors: {address byte, data byte, expected address ACK}, own address 0x3A
    localparam logic [16:0] VEC [0:5] = '{
        {8'h74, 8'h11, 1'b1}, {8'h76, 8'h22, 1'b0}, {8'h74, 8'h00, 1'b1},
        {8'h74, 8'hFF, 1'b1}, {8'h14, 8'h55, 1'b0}, {8'h74, 8'h80, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        m_sda_low = 1'b0; wait_clk(Q);
    endtask

    task automatic bit_w(input logic b);
        m_sda_low = !b; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
        m_scl_low = 1'b1; wait_clk(4);
    endtask

    task automatic bit_r(output logic b);
        m_sda_low = 1'b0; wait_clk(Q);
        m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q / 2);
        b = sda_line; wait_clk(Q / 2);
        m_scl_low = 1'b1; wait_clk(4);
    endtask

    task automatic byte_w(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(a);
        ack = !a;
    endtask

    task automatic byte_r(output logic [7:0] d, input logic ack);
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        bit_w(!ack);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R2: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic ack;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        reg_rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        reg_rd(3'd1, d); chk("R1 addr main", d, 8'h00);
        reg_rd(3'd2, d); chk("R1 addr low", d, 8'h00);
        reg_rd(3'd3, d); chk("R1 status", d, 8'h00);
        chk("R1 outputs", {5'd0, scl_oe, sda_oe, irq}, 8'h00);

        reg_wr(3'd1, 8'h3A);
        reg_wr(3'd4, 8'hA5);

        // table walk: R3 address match, R4 data, R2 stop flag
        foreach (VEC[k]) begin
            reg_wr(3'd3, 8'h07);
            m_start();
            byte_w(VEC[k][16:9], ack);
            chk("R3 address ack", {7'd0, ack}, {7'd0, VEC[k][0]});
            if (VEC[k][0]) begin
                byte_w(VEC[k][8:1], ack);
                chk("R4 data ack", {7'd0, ack}, 8'h01);
                reg_rd(3'd5, d); chk("R4 rx byte", d, VEC[k][8:1]);
                reg_rd(3'd3, d); chk("R4 rx flag", {7'd0, d[1]}, 8'h01);
            end else begin
                reg_rd(3'd3, d); chk("R3 ignored, no rx flag", {7'd0, d[1]}, 8'h00);
            end
            m_stop(); wait_clk(8);
            reg_rd(3'd3, d); chk("R2 stop flag", {7'd0, d[2]}, 8'h01);
        end

        // R11 write-1-to-clear (status now rx|stop)
        reg_wr(3'd3, 8'h02);
        reg_rd(3'd3, d); chk("R11 partial clear", d, 8'h04);
        reg_wr(3'd3, 8'h04);
        reg_rd(3'd3, d); chk("R11 full clear", d, 8'h00);

        // R12 interrupt gating
        reg_wr(3'd0, 8'h10);
        m_start(); byte_w(8'h74, ack); byte_w(8'h5C, ack); m_stop(); wait_clk(8);
        chk("R12 irq on rx", {7'd0, irq}, 8'h01);
        reg_wr(3'd3, 8'h02); wait_clk(1);
        chk("R12 stop flag masked", {7'd0, irq}, 8'h00);
        reg_wr(3'd0, 8'h30); wait_clk(1);
        chk("R12 stop enabled", {7'd0, irq}, 8'h01);
        reg_wr(3'd3, 8'h07); reg_wr(3'd0, 8'h00);

        // R5 read from target
        m_start(); byte_w(8'h75, ack);
        chk("R5 read address ack", {7'd0, ack}, 8'h01);
        byte_r(d, 1'b1); chk("R5 first byte", d, 8'hA5);
        byte_r(d, 1'b0); chk("R5 repeat byte", d, 8'hA5);
        reg_rd(3'd3, d); chk("R5 tx flag", {7'd0, d[0]}, 8'h01);
        chk("R5 sda released", {7'd0, sda_oe}, 8'h00);
        m_stop(); reg_wr(3'd3, 8'h07);

        // R8 forced NACK on the address, one-shot
        reg_wr(3'd0, 8'h04);
        m_start(); byte_w(8'h74, ack); m_stop();
        chk("R8 address nacked", {7'd0, ack}, 8'h00);
        reg_rd(3'd0, d); chk("R8 self-clear", d, 8'h00);
        m_start(); byte_w(8'h74, ack);
        chk("R8 next transfer normal", {7'd0, ack}, 8'h01);
        reg_wr(3'd0, 8'h04);
        byte_w(8'h99, ack); chk("R8 data nacked", {7'd0, ack}, 8'h00);
        reg_rd(3'd5, d); chk("R8 nacked byte stored", d, 8'h99);
        byte_w(8'h11, ack); chk("R8 rest ignored", {7'd0, ack}, 8'h00);
        reg_rd(3'd5, d); chk("R8 rx unchanged", d, 8'h99);
        m_stop(); reg_wr(3'd3, 8'h07);

        // R9 stretch requested while SCL low
        m_start(); byte_w(8'h74, ack);
        reg_wr(3'd0, 8'h02); wait_clk(6);
        chk("R9 hold asserted", {7'd0, scl_oe}, 8'h01);
        wait_clk(30);
        chk("R9 hold kept", {7'd0, scl_oe}, 8'h01);
        reg_wr(3'd0, 8'h00); wait_clk(6);
        chk("R9 hold released", {7'd0, scl_oe}, 8'h00);
        byte_w(8'h42, ack);
        reg_rd(3'd5, d); chk("R9 transfer after hold", d, 8'h42);
        m_stop(); reg_wr(3'd3, 8'h07);

        // R10 stretch requested while SCL high
        reg_wr(3'd0, 8'h02); wait_clk(30);
        chk("R10 no hold while high", {7'd0, scl_oe}, 8'h00);
        m_start();
        chk("R10 hold after fall", {7'd0, scl_oe}, 8'h01);
        m_scl_low = 1'b0; wait_clk(20);
        chk("R10 line held low", {7'd0, scl_line}, 8'h00);
        reg_wr(3'd0, 8'h00); wait_clk(6);
        chk("R10 line released", {7'd0, scl_line}, 8'h01);
        m_scl_low = 1'b1; wait_clk(Q);
        m_stop(); reg_wr(3'd3, 8'h07);

        // R6 / R7 10-bit addressing, high bits 2'b10, low byte 0x5A
        reg_wr(3'd0, 8'h01); reg_wr(3'd1, 8'h02); reg_wr(3'd2, 8'h5A);
        m_start(); byte_w(8'hF4, ack);
        chk("R6 header ack", {7'd0, ack}, 8'h01);
        byte_w(8'h5A, ack); chk("R6 low byte ack", {7'd0, ack}, 8'h01);
        byte_w(8'h3C, ack);
        reg_rd(3'd5, d); chk("R6 data", d, 8'h3C);
        m_start(); byte_w(8'hF5, ack);
        chk("R7 read header ack", {7'd0, ack}, 8'h01);
        byte_r(d, 1'b0); chk("R7 read data", d, 8'hA5);
        m_stop();
        m_start(); byte_w(8'hF4, ack); byte_w(8'h5B, ack);
        chk("R6 low mismatch nack", {7'd0, ack}, 8'h00);
        m_stop();
        m_start(); byte_w(8'hF5, ack);
        chk("R7 read header without match", {7'd0, ack}, 8'h00);
        m_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule